// File: doc/BRIEF.md
# Triple Timer Status and Control Register

This block is one 32-bit control and status word that governs three independent interval timers. Software reaches it over a plain register bus: an address, a write strobe, write data and combinational read data. Each timer gets a pair of write-one strobe bits, one to start it and one to stop it. There is also a sticky interrupt flag and a sticky overflow flag for each timer. Both flags are cleared by writing a one to them.

Each timer is a free-running up-counter of `CNT_W` bits. Starting a timer zeroes its counter and arms a fixed three-cycle start delay. After the delay the timer's run output goes high and the counter advances once per clock. The interrupt flag latches when the count reaches `PERIOD-1`. The overflow flag latches when the counter wraps from all ones to zero. Both flags also drive level outputs, so every timer has its own request lines.

Top module: `tri_timer_ctl`

## Requirements
- R1: The status word has this layout. Bits 2:0 are the interrupt flags of timers 2..0 and bits 6:4 are their overflow flags. Bits 8, 10 and 12 read back the enabled state of timers 0, 1 and 2. The stop bits 9, 11 and 13, the spare bits 3 and 7, and bits 31:14 always read zero.
- R2: Writing one to a timer's start bit (8, 10 or 12) sets its enabled bit. Writing the start bit again while the timer is already enabled has no effect and does not restart the delay.
- R3: A timer's run output rises exactly three clock edges after the edge that captures its start write. Run is never high while the timer is disabled.
- R4: Writing one to a timer's stop bit (9, 11 or 13) clears its enabled bit and its run output on the edge that captures the write.
- R5: When the start and stop bits of one timer are both one in the same write, the stop wins. A stop that arrives during the three-cycle start delay cancels the start, and run never rises.
- R6: The interrupt flag sets on the edge where the running count moves past `PERIOD-1`. That edge is `3+PERIOD` edges after the start write. The flag sets again every `2**CNT_W` edges after that.
- R7: The overflow flag sets on the edge where the counter wraps. That edge is `3+2**CNT_W` edges after the start write.
- R8: Writing one to a flag bit clears that flag. Writing zero to any bit, or writing the spare bits, changes nothing.
- R9: If a flag's event and a clearing write of that flag fall on the same edge, the flag stays one.
- R10: The outputs `irq` and `ovf` equal the interrupt and overflow flag bits of the status word at all times.
- R11: A write that touches only one timer's bits leaves the other timers' run, enable and flags unchanged.
- R12: After reset, all flags, enables and run outputs are zero.
- R13: A write at an address other than `REG_ADDR` is ignored. A read at any other address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register bus address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (status word when the address matches, else zero) |
| run | output | 3 | Per-timer counting indicator |
| irq | output | 3 | Per-timer interrupt flag level |
| ovf | output | 3 | Per-timer overflow flag level |

## Verification
On every cycle, the assertions check the following rules:
- a rising run edge is preceded by exactly three cycles of enable;
- a stop write clears run and enable on the next edge;
- a flag event always lands in its flag, even when a clear is written on the same edge;
- a clearing write empties the flag;
- a flag with no event and no clear holds its value.

Other behaviour shows only in the bench's scenarios:
- the exact edge where an interrupt or overflow first appears;
- the cancelling of a pending start, swept over every stop offset;
- the readback layout and the address decode;
- the independence of the three timers.

// File: rtl/tri_timer_ctl.sv
module tri_timer_ctl #(
  parameter int ADDR_W    = 8,
  parameter int REG_ADDR  = 'h20,
  parameter int CNT_W     = 32,
  parameter int PERIOD    = 1000,
  parameter int START_DLY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [2:0]        run,
  output logic [2:0]        irq,
  output logic [2:0]        ovf
);
  localparam int NT    = 3;
  localparam int DLY_W = $clog2(START_DLY + 1);
  localparam logic [CNT_W-1:0] MATCH = CNT_W'(PERIOD - 1);

  logic          addr_hit, wr_hit;
  logic [NT-1:0] en_q, irq_q, ovf_q, irq_evt, ovf_evt;
  logic [31:0]   status;

  assign addr_hit = (reg_addr == ADDR_W'(REG_ADDR));
  assign wr_hit   = reg_we & addr_hit;

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    logic [DLY_W-1:0] dly_q;
    logic [CNT_W-1:0] cnt_q;
    logic             start, stop;

    assign stop       = wr_hit & reg_wdata[9+2*i];
    assign start      = wr_hit & reg_wdata[8+2*i] & ~en_q[i];
    assign run[i]     = en_q[i] & (dly_q == '0);
    assign irq_evt[i] = run[i] & (cnt_q == MATCH);
    assign ovf_evt[i] = run[i] & (cnt_q == '1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[i] <= 1'b0;
        dly_q   <= '0;
        cnt_q   <= '0;
      end else if (stop) begin
        en_q[i] <= 1'b0;
        dly_q   <= '0;
      end else if (start) begin
        en_q[i] <= 1'b1;
        dly_q   <= DLY_W'(START_DLY);
        cnt_q   <= '0;
      end else if (en_q[i] && dly_q != '0) begin
        dly_q   <= dly_q - 1'b1;
      end else if (run[i]) begin
        cnt_q   <= cnt_q + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        irq_q[i] <= 1'b0;
        ovf_q[i] <= 1'b0;
      end else begin
        irq_q[i] <= irq_evt[i] | (irq_q[i] & ~(wr_hit & reg_wdata[i]));
        ovf_q[i] <= ovf_evt[i] | (ovf_q[i] & ~(wr_hit & reg_wdata[4+i]));
      end
    end
  end

  always_comb begin
    status = '0;
    for (int i = 0; i < NT; i++) begin
      status[i]     = irq_q[i];
      status[4+i]   = ovf_q[i];
      status[8+2*i] = en_q[i];
    end
  end

  assign reg_rdata = addr_hit ? status : '0;
  assign irq       = irq_q;
  assign ovf       = ovf_q;
endmodule

module tri_timer_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_hit,
  input logic [31:0] wdata,
  input logic [2:0]  en,
  input logic [2:0]  run,
  input logic [2:0]  irq,
  input logic [2:0]  ovf,
  input logic [2:0]  irq_evt,
  input logic [2:0]  ovf_evt
);
  for (genvar i = 0; i < 3; i++) begin : g_chk
    AST_START_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run[i]) |-> ($past(en[i],1) && $past(en[i],2) && $past(en[i],3) && !$past(en[i],4))); // R3
    AST_RUN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      run[i] |-> en[i]); // R3
    AST_STOP_NOW: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && wdata[9+2*i]) |=> (!run[i] && !en[i])); // R4
    AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      irq_evt[i] |=> irq[i]); // R9
    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt[i] |=> ovf[i]); // R7
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && wdata[i] && !irq_evt[i]) |=> !irq[i]); // R8
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_evt[i] && !(wr_hit && wdata[i])) |=> (irq[i] == $past(irq[i]))); // R8
  end
endmodule

bind tri_timer_ctl tri_timer_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wdata(reg_wdata), .en(en_q),
  .run(run), .irq(irq), .ovf(ovf), .irq_evt(irq_evt), .ovf_evt(ovf_evt)
);

// File: tb/tri_timer_ctl_tb.sv
module tri_timer_ctl_tb;
  localparam int CW = 4;
  localparam int P  = 5;
  localparam logic [7:0] RA = 8'h20;

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [7:0]  reg_addr = RA;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0]  run, irq, ovf;
  int n_chk = 0, n_fail = 0, cyc = 0, w = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tri_timer_ctl #(.ADDR_W(8), .REG_ADDR(RA), .CNT_W(CW), .PERIOD(P), .START_DLY(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .run(run), .irq(irq), .ovf(ovf));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0; reg_addr = RA;
  endtask

  task automatic wait_edge(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 reset rdata", reg_rdata, 32'h0);
    check("R12 reset outputs", {23'h0, run, irq, ovf}, 32'h0);

    // R5 / R3 / R11 sweep: stop offset d (0 = same write) for each timer
    for (int t = 0; t < 3; t++) begin
      for (int d = 0; d <= 4; d++) begin
        if (d == 0) wr(RA, 32'h3 << (8 + 2*t));
        else        wr(RA, 32'h1 << (8 + 2*t));
        check("R5 run at write edge", {29'h0, run}, 32'h0);
        for (int k = 1; k <= 5; k++) begin
          bit er, ee;
          if (k == d) wr(RA, 32'h2 << (8 + 2*t));
          else        @(negedge clk);
          er = (d != 0) && (k >= 3) && (k < d);
          ee = (d != 0) && (k < d);
          check("R3 R5 R11 run sweep", {29'h0, run}, er ? (32'h1 << t) : 32'h0);
          check("R1 R2 enable readback", reg_rdata, ee ? (32'h1 << (8 + 2*t)) : 32'h0);
        end
      end
    end

    // R2 / R11: timer 1 alone, re-enable has no effect
    wr(RA, 32'h1 << 10); w = cyc;
    wait_edge(w + 3);
    check("R11 only timer1 runs", {29'h0, run}, 32'h2);
    check("R1 readback timer1", reg_rdata, 32'h400);
    wr(RA, 32'h1 << 10);
    check("R2 re-enable keeps run", {29'h0, run}, 32'h2);
    wr(RA, 32'h1 << 11);
    check("R4 stop timer1", {29'h0, run}, 32'h0);
    check("R4 stop readback", reg_rdata, 32'h0);

    // R6 / R7 / R10: event timing on timer 0
    wr(RA, 32'h1 << 8); w = cyc;
    wait_edge(w + P + 2);
    check("R6 irq not yet", {29'h0, irq}, 32'h0);
    wait_edge(w + P + 3);
    check("R6 irq sets", {29'h0, irq}, 32'h1);
    check("R10 irq readback", reg_rdata, 32'h101);
    wait_edge(w + 2 + (1 << CW));
    check("R7 ovf not yet", {29'h0, ovf}, 32'h0);
    wait_edge(w + 3 + (1 << CW));
    check("R7 ovf sets", {29'h0, ovf}, 32'h1);
    check("R10 ovf readback", reg_rdata, 32'h111);

    // R8: spare and zero writes
    wr(RA, 32'hFFFF_C088);
    check("R8 spare write ignored", reg_rdata, 32'h111);
    wr(RA, 32'h0);
    check("R8 zero write ignored", reg_rdata, 32'h111);
    check("R10 outputs hold", {26'h0, ovf, irq}, 32'h09);
    wr(RA, 32'h11);
    check("R8 w1c clears", reg_rdata, 32'h100);
    check("R8 w1c outputs", {26'h0, ovf, irq}, 32'h0);

    // R9: clear on the same edge as the next event
    wait_edge(w + P + 2 + (1 << CW));
    wr(RA, 32'h1);
    check("R9 set wins", {29'h0, irq}, 32'h1);
    wr(RA, 32'h1);
    check("R8 later clear", {29'h0, irq}, 32'h0);

    // R13: address decode
    wr(RA ^ 8'h01, 32'h1 << 12);
    repeat (4) @(negedge clk);
    check("R13 foreign write ignored", {29'h0, run}, 32'h1);
    reg_addr = RA ^ 8'h01; #1;
    check("R13 foreign read zero", reg_rdata, 32'h0);
    reg_addr = RA;
    wr(RA, 32'h1 << 9);
    check("R4 stop timer0", {29'h0, run}, 32'h0);

    finish_run();
  end
endmodule